// File: doc/BRIEF.md
# Accumulator Arithmetic Execute Unit

This unit carries out the accumulator-side instructions of a small 19-bit microcontroller instruction set. It owns the two data registers of the core. The working accumulator is `acc` and the spare register is `dat`. Both hold signed decimal values from -999 to 999. Instruction fetch, condition evaluation and operand lookup happen upstream. Each cycle the unit receives the instruction word, an execute strobe that is already qualified by the condition logic, and the resolved operand values. The unit applies the instruction on the next rising clock edge.

The supported operations are: register loads, saturating add, subtract and multiply, a logical NOT, and two decimal-digit operations. One digit operation extracts a digit of `acc`; the other replaces a digit of `acc`. A load whose destination is one of the six port registers does not change `acc` or `dat`. Instead the unit raises a one-cycle write strobe with the port number and the value, so that an external port block can take the value. The unit presents `acc` and `dat` on its outputs so that the upstream operand resolver can read them.

Top module: `acu_core`

## Requirements
- R1: While reset is asserted, and after it is released, `acc_out` and `dat_out` read 0 and `port_wr` is low.
- R2: A load (instr[16:14]=000) with destination instr[2:0]=000 writes `opnd_val` into `acc`. With destination 001 it writes `opnd_val` into `dat`. The other register keeps its value.
- R3: A load with destination 010..111 raises `port_wr` for exactly one cycle. `port_id` carries the destination and `port_val` carries `opnd_val`. Neither `acc` nor `dat` changes.
- R4: Add (instr[16:12]=01011) writes acc+`opnd_val`, saturated to [-999, 999], into `acc`.
- R5: Subtract (instr[16:12]=01100) writes acc-`opnd_val`, saturated to [-999, 999], into `acc`.
- R6: Multiply (instr[16:12]=01101) writes acc*`opnd_val`, saturated to [-999, 999], into `acc`.
- R7: NOT (instr[16:11]=011110) writes 100 into `acc` when `acc` is 0, and writes 0 otherwise.
- R8: Digit-get (instr[16:11]=011100) takes its selector from instr[4:0]. When bit 4 is clear, bits 3:0 are an immediate selector. When bit 4 is set, the selector is `sel_val`. Selector 0 picks the ones digit of |acc|, 1 picks the tens digit and 2 picks the hundreds digit. The picked digit is written to `acc` with the sign of `acc` applied.
- R9: Digit-set (instr[16:11]=011101) takes its selector from instr[4:0], resolved as in R8, and its value from instr[9:5]. When bit 4 of the value field is clear, bits 3:0 are an immediate digit. When bit 4 is set, the value is the low decimal digit of |`opnd_val`|. The unit replaces the selected digit of |acc| with the value and keeps the sign of `acc`.
- R10: A digit instruction does nothing in the following cases: the selector resolves outside 0..2, which includes the immediate code 0xF; or, for digit-set, the immediate value field is above 9, which includes 0xF.
- R11: With `exec_en` low, or with an opcode outside R2..R9 (for example compares, jumps, sleeps), `acc` and `dat` keep their values and `port_wr` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| exec_en | input | 1 | Condition-qualified execute strobe |
| instr | input | 19 | Instruction word |
| opnd_val | input | DATA_W | Resolved register/immediate operand value |
| sel_val | input | DATA_W | Resolved digit selector value when the selector names a register |
| acc_out | output | DATA_W | Accumulator value, signed |
| dat_out | output | DATA_W | Spare register value, signed |
| port_wr | output | 1 | One-cycle port write strobe |
| port_id | output | 3 | Destination register number of the port write |
| port_val | output | DATA_W | Value carried by the port write |

## Verification
The bench builds the unit with its default parameters: an 11-bit data path, a limit of 999 and three decimal digits. With this configuration, products of two ±999 values reach far past both saturation limits. The ±999 corners are hit exactly by the operand sweep, whose step of 37 lands on both ends. Every digit position is reachable with both signs of `acc`. The sweeps cover a grid of accumulator and operand values for the three arithmetic operations. They cover every selector with both immediate and register forms for the digit operations, and every immediate digit value for digit-set. The bench also applies the 0xF and out-of-range selector codes, the six port destinations and a set of foreign opcodes.

// File: rtl/acu_pkg.sv
package acu_pkg;

  typedef enum logic [2:0] {
    K_NONE,
    K_MOV,
    K_ADD,
    K_SUB,
    K_MUL,
    K_NOT,
    K_DGT,
    K_DST
  } acu_kind_e;

  localparam int INSTR_W = 19;

endpackage

// File: rtl/acu_decode.sv
module acu_decode
  import acu_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output acu_kind_e          kind,
  output logic [2:0]         dest
);

  logic [2:0] major;
  logic [1:0] minor2;
  logic [2:0] minor3;

  assign major  = instr[16:14];
  assign minor2 = instr[13:12];
  assign minor3 = instr[13:11];
  assign dest   = instr[2:0];

  always_comb begin
    kind = K_NONE;
    case (major)
      3'b000: kind = K_MOV;
      3'b010: if (minor2 == 2'b11) kind = K_ADD;
      3'b011: begin
        case (minor2)
          2'b00:   kind = K_SUB;
          2'b01:   kind = K_MUL;
          default: begin
            case (minor3)
              3'b110:  kind = K_NOT;
              3'b100:  kind = K_DGT;
              3'b101:  kind = K_DST;
              default: kind = K_NONE;
            endcase
          end
        endcase
      end
      default: kind = K_NONE;
    endcase
  end

endmodule

// File: rtl/acu_arith.sv
module acu_arith
  import acu_pkg::*;
#(
  parameter int DATA_W   = 11,
  parameter int LIMIT    = 999,
  parameter int TRUE_VAL = 100
) (
  input  acu_kind_e                 kind,
  input  logic signed [DATA_W-1:0]  acc,
  input  logic signed [DATA_W-1:0]  opnd,
  output logic signed [DATA_W-1:0]  result
);

  localparam int PW = 2 * DATA_W + 2;
  localparam logic signed [PW-1:0]     HI_W = PW'(LIMIT);
  localparam logic signed [PW-1:0]     LO_W = -HI_W;
  localparam logic signed [DATA_W-1:0] HI_N = DATA_W'(LIMIT);
  localparam logic signed [DATA_W-1:0] LO_N = -HI_N;

  logic signed [PW-1:0] a_x;
  logic signed [PW-1:0] b_x;
  logic signed [PW-1:0] wide;

  always_comb begin
    a_x = PW'(acc);
    b_x = PW'(opnd);
    case (kind)
      K_ADD:   wide = a_x + b_x;
      K_SUB:   wide = a_x - b_x;
      K_MUL:   wide = a_x * b_x;
      default: wide = (acc == '0) ? PW'(TRUE_VAL) : '0;
    endcase
    if (wide > HI_W)      result = HI_N;
    else if (wide < LO_W) result = LO_N;
    else                  result = wide[DATA_W-1:0];
  end

endmodule

// File: rtl/acu_digit.sv
module acu_digit #(
  parameter int DATA_W = 11,
  parameter int NDIG   = 3
) (
  input  logic                      is_dst,
  input  logic [4:0]                sel_raw,
  input  logic [4:0]                val_raw,
  input  logic signed [DATA_W-1:0]  acc,
  input  logic signed [DATA_W-1:0]  sel_val,
  input  logic signed [DATA_W-1:0]  opnd_val,
  output logic                      apply,
  output logic signed [DATA_W-1:0]  result
);

  function automatic int pow10(int n);
    int r;
    r = 1;
    for (int i = 0; i < n; i++) r = r * 10;
    return r;
  endfunction

  localparam logic [DATA_W-1:0]        TEN    = DATA_W'(10);
  localparam logic signed [DATA_W-1:0] ZERO_S = '0;
  localparam logic signed [DATA_W-1:0] NDIG_S = DATA_W'(NDIG);

  logic [DATA_W-1:0]        mag;
  logic [DATA_W-1:0]        vmag;
  logic [DATA_W-1:0]        dig [NDIG];
  logic signed [DATA_W-1:0] sel_s;
  logic                     sel_ok;
  logic                     val_ok;
  logic [DATA_W-1:0]        pick;
  logic [DATA_W-1:0]        scale;
  logic [DATA_W-1:0]        vdig;
  logic [DATA_W-1:0]        new_mag;

  assign mag  = acc[DATA_W-1] ? DATA_W'(-acc) : DATA_W'(acc);
  assign vmag = opnd_val[DATA_W-1] ? DATA_W'(-opnd_val) : DATA_W'(opnd_val);

  for (genvar k = 0; k < NDIG; k++) begin : g_dig
    localparam logic [DATA_W-1:0] SC = DATA_W'(pow10(k));
    assign dig[k] = (mag / SC) % TEN;
  end

  always_comb begin
    sel_s  = sel_raw[4] ? sel_val : $signed(DATA_W'(sel_raw[3:0]));
    sel_ok = (sel_s >= ZERO_S) && (sel_s < NDIG_S);
    pick   = '0;
    scale  = '0;
    for (int k = 0; k < NDIG; k++) begin
      if (sel_s == DATA_W'(k)) begin
        pick  = dig[k];
        scale = DATA_W'(pow10(k));
      end
    end
    if (val_raw[4]) begin
      vdig   = vmag % TEN;
      val_ok = 1'b1;
    end else begin
      vdig   = DATA_W'(val_raw[3:0]);
      val_ok = (val_raw[3:0] <= 4'd9);
    end
    apply   = sel_ok && (!is_dst || val_ok);
    new_mag = is_dst ? (mag - pick * scale + vdig * scale) : pick;
    result  = acc[DATA_W-1] ? -$signed(new_mag) : $signed(new_mag);
  end

endmodule

// File: rtl/acu_core.sv
module acu_core
  import acu_pkg::*;
#(
  parameter int DATA_W   = 11,
  parameter int LIMIT    = 999,
  parameter int TRUE_VAL = 100,
  parameter int NDIG     = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      exec_en,
  input  logic [INSTR_W-1:0]        instr,
  input  logic signed [DATA_W-1:0]  opnd_val,
  input  logic signed [DATA_W-1:0]  sel_val,
  output logic signed [DATA_W-1:0]  acc_out,
  output logic signed [DATA_W-1:0]  dat_out,
  output logic                      port_wr,
  output logic [2:0]                port_id,
  output logic signed [DATA_W-1:0]  port_val
);

  localparam logic signed [DATA_W-1:0] HI_N = DATA_W'(LIMIT);
  localparam logic signed [DATA_W-1:0] TV_N = DATA_W'(TRUE_VAL);

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  acu_kind_e                kind;
  logic [2:0]               dest;
  logic signed [DATA_W-1:0] arith_res;
  logic signed [DATA_W-1:0] digit_res;
  logic                     digit_apply;

  acu_decode i_dec (
    .instr (instr),
    .kind  (kind),
    .dest  (dest)
  );

  acu_arith #(.DATA_W(DATA_W), .LIMIT(LIMIT), .TRUE_VAL(TRUE_VAL)) i_arith (
    .kind   (kind),
    .acc    (acc_out),
    .opnd   (opnd_val),
    .result (arith_res)
  );

  acu_digit #(.DATA_W(DATA_W), .NDIG(NDIG)) i_digit (
    .is_dst   (kind == K_DST),
    .sel_raw  (instr[4:0]),
    .val_raw  (instr[9:5]),
    .acc      (acc_out),
    .sel_val  (sel_val),
    .opnd_val (opnd_val),
    .apply    (digit_apply),
    .result   (digit_res)
  );

  // next state
  logic                     acc_en, dat_en, port_en;
  logic signed [DATA_W-1:0] acc_d;

  always_comb begin
    acc_en  = 1'b0;
    dat_en  = 1'b0;
    port_en = 1'b0;
    acc_d   = acc_out;
    if (exec_en) begin
      case (kind)
        K_MOV: begin
          if (dest == 3'd0) begin
            acc_en = 1'b1;
            acc_d  = opnd_val;
          end else if (dest == 3'd1) begin
            dat_en = 1'b1;
          end else begin
            port_en = 1'b1;
          end
        end
        K_ADD, K_SUB, K_MUL, K_NOT: begin
          acc_en = 1'b1;
          acc_d  = arith_res;
        end
        K_DGT, K_DST: begin
          acc_en = digit_apply;
          acc_d  = digit_res;
        end
        default: ;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      acc_out  <= '0;
      dat_out  <= '0;
      port_wr  <= 1'b0;
      port_id  <= '0;
      port_val <= '0;
    end else begin
      port_wr <= port_en;
      if (acc_en)  acc_out <= acc_d;
      if (dat_en)  dat_out <= opnd_val;
      if (port_en) begin
        port_id  <= dest;
        port_val <= opnd_val;
      end
    end
  end

  // R3
  port_pulse_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    port_wr |-> $past(exec_en));

  // R3
  port_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    port_wr |-> ($stable(acc_out) && $stable(dat_out)));

  // R4
  acc_range_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (acc_out <= HI_N) && (acc_out >= -HI_N));

  // R2
  dat_range_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (dat_out <= HI_N) && (dat_out >= -HI_N));

  // R7
  not_value_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (exec_en && kind == K_NOT) |=> ((acc_out == '0) || (acc_out == TV_N)));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!exec_en || kind == K_NONE) |=> (!port_wr && $stable(acc_out) && $stable(dat_out)));

endmodule

// File: tb/test_acu_core.sv
`timescale 1ns/1ps
module test_acu_core;

  localparam int W = 11;

  logic                clk;
  logic                rst_n;
  logic                exec_en;
  logic [18:0]         instr;
  logic signed [W-1:0] opnd_val;
  logic signed [W-1:0] sel_val;
  logic signed [W-1:0] acc_out;
  logic signed [W-1:0] dat_out;
  logic                port_wr;
  logic [2:0]          port_id;
  logic signed [W-1:0] port_val;

  int n_chk;
  int n_bad;
  bit done;

  acu_core i_acu_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .exec_en  (exec_en),
    .instr    (instr),
    .opnd_val (opnd_val),
    .sel_val  (sel_val),
    .acc_out  (acc_out),
    .dat_out  (dat_out),
    .port_wr  (port_wr),
    .port_id  (port_id),
    .port_val (port_val)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  localparam logic [18:0] OP_ADD = 19'h0B000;
  localparam logic [18:0] OP_SUB = 19'h0C000;
  localparam logic [18:0] OP_MUL = 19'h0D000;
  localparam logic [18:0] OP_NOT = 19'h0F000;
  localparam logic [18:0] OP_DGT = 19'h0E000;
  localparam logic [18:0] OP_DST = 19'h0E800;

  function automatic int sat(int v);
    if (v > 999)  return 999;
    if (v < -999) return -999;
    return v;
  endfunction

  function automatic int p10(int k);
    return (k == 0) ? 1 : (k == 1) ? 10 : 100;
  endfunction

  function automatic int iabs(int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run(logic [18:0] ins, int o, int s);
    @(negedge clk);
    instr    = ins;
    opnd_val = W'(o);
    sel_val  = W'(s);
    exec_en  = 1'b1;
    @(negedge clk);
    exec_en  = 1'b0;
  endtask

  task automatic load_acc(int v);
    run(19'h00000, v, 0);
  endtask

  initial begin
    #(20.0 * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    n_chk = 0;
    n_bad = 0;
    done = 1'b0;
    rst_n = 1'b0;
    exec_en = 1'b0;
    instr = '0;
    opnd_val = '0;
    sel_val = '0;
    repeat (4) @(negedge clk);
    // R1 during reset
    chk("R1 acc in reset", int'(acc_out), 0);
    chk("R1 port_wr in reset", int'(port_wr), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 acc", int'(acc_out), 0);
    chk("R1 dat", int'(dat_out), 0);
    chk("R1 port_wr", int'(port_wr), 0);

    // R2 loads
    run(19'h00001, 321, 0);
    chk("R2 dat load", int'(dat_out), 321);
    chk("R2 acc kept", int'(acc_out), 0);
    for (int v = -999; v <= 999; v += 111) begin
      load_acc(v);
      chk("R2 acc load", int'(acc_out), v);
      chk("R2 dat kept", int'(dat_out), 321);
    end
    run(19'h00001, -999, 0);
    chk("R2 dat load neg", int'(dat_out), -999);

    // R3 port writes
    load_acc(55);
    for (int d = 2; d < 8; d++) begin
      run(19'(d), 100 * d - 450, 0);
      chk("R3 strobe", int'(port_wr), 1);
      chk("R3 id", int'(port_id), d);
      chk("R3 value", int'(port_val), 100 * d - 450);
      chk("R3 acc kept", int'(acc_out), 55);
      chk("R3 dat kept", int'(dat_out), -999);
      @(negedge clk);
      chk("R3 one cycle", int'(port_wr), 0);
    end

    // R4 R5 R6 arithmetic sweep
    for (int a = -999; a <= 999; a += 37) begin
      for (int b = -999; b <= 999; b += 37) begin
        load_acc(a);
        run(OP_ADD, b, 0);
        chk("R4 add", int'(acc_out), sat(a + b));
        load_acc(a);
        run(OP_SUB, b, 0);
        chk("R5 sub", int'(acc_out), sat(a - b));
        load_acc(a);
        run(OP_MUL, b, 0);
        chk("R6 mul", int'(acc_out), sat(a * b));
      end
    end

    // R7 NOT
    for (int a = -999; a <= 999; a += 27) begin
      load_acc(a);
      run(OP_NOT, 0, 0);
      chk("R7 not", int'(acc_out), (a == 0) ? 100 : 0);
    end
    load_acc(0);
    run(OP_NOT, 0, 0);
    chk("R7 not zero", int'(acc_out), 100);
    run(OP_NOT, 0, 0);
    chk("R7 not hundred", int'(acc_out), 0);

    // R8 digit get, immediate and register selector
    for (int a = -999; a <= 999; a += 7) begin
      for (int k = 0; k < 3; k++) begin
        int dg;
        dg = (iabs(a) / p10(k)) % 10;
        load_acc(a);
        run(OP_DGT | 19'(k), 0, 0);
        chk("R8 dgt imm", int'(acc_out), (a < 0) ? -dg : dg);
        load_acc(a);
        run(OP_DGT | 19'h10, 0, k);
        chk("R8 dgt reg", int'(acc_out), (a < 0) ? -dg : dg);
      end
    end

    // R9 digit set
    for (int a = -999; a <= 999; a += 13) begin
      for (int k = 0; k < 3; k++) begin
        for (int v = 0; v < 10; v++) begin
          int m;
          m = iabs(a);
          m = m - ((m / p10(k)) % 10) * p10(k) + v * p10(k);
          load_acc(a);
          run(OP_DST | 19'(v << 5) | 19'(k), 0, 0);
          chk("R9 dst imm", int'(acc_out), (a < 0) ? -m : m);
        end
      end
    end
    load_acc(-512);
    run(OP_DST | 19'h200 | 19'h10, -47, 1);
    chk("R9 dst reg value", int'(acc_out), -572);
    load_acc(300);
    run(OP_DST | 19'h200 | 19'h02, 86, 0);
    chk("R9 dst reg value hundreds", int'(acc_out), 600);

    // R10 no-op digit codes
    load_acc(-374);
    run(OP_DGT | 19'h0F, 0, 0);
    chk("R10 dgt 0xF", int'(acc_out), -374);
    run(OP_DGT | 19'h03, 0, 0);
    chk("R10 dgt sel 3", int'(acc_out), -374);
    run(OP_DGT | 19'h10, 0, -1);
    chk("R10 dgt reg -1", int'(acc_out), -374);
    run(OP_DGT | 19'h10, 0, 3);
    chk("R10 dgt reg 3", int'(acc_out), -374);
    run(OP_DST | 19'(5 << 5) | 19'h0F, 0, 0);
    chk("R10 dst sel 0xF", int'(acc_out), -374);
    run(OP_DST | 19'(15 << 5) | 19'h01, 0, 0);
    chk("R10 dst val 0xF", int'(acc_out), -374);
    run(OP_DST | 19'(12 << 5) | 19'h00, 0, 0);
    chk("R10 dst val 12", int'(acc_out), -374);

    // R11 idle and foreign opcodes
    run(19'h00001, 77, 0);
    load_acc(250);
    @(negedge clk);
    instr = OP_ADD;
    opnd_val = W'(5);
    exec_en = 1'b0;
    @(negedge clk);
    chk("R11 idle acc", int'(acc_out), 250);
    instr = 19'h00003;
    @(negedge clk);
    chk("R11 idle port", int'(port_wr), 0);
    run(19'h10000 | 19'h00008, 9, 0);
    chk("R11 compare acc", int'(acc_out), 250);
    chk("R11 compare port", int'(port_wr), 0);
    run(19'h08000 | 19'h00003, 9, 0);
    chk("R11 jump acc", int'(acc_out), 250);
    run(19'h09000 | 19'h00004, 9, 0);
    chk("R11 sleep acc", int'(acc_out), 250);
    run(19'h0F800 | 19'h00003, 9, 0);
    chk("R11 set-flags acc", int'(acc_out), 250);
    chk("R11 dat kept", int'(dat_out), 77);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule